// File: doc/BRIEF.md
# Falling-Edge Scratchpad Memory with Self-Clearing Request Toggle

This block is a single-port word store meant to hold the stack of a generated state machine. The controller logic runs on the rising clock edge, while the storage array and its request-tracking flag update on the falling edge. Working half a cycle out of phase lets a store finish inside the controller cycle that issued it. A load result is ready to be captured on the very next rising edge.

A request is signalled by toggling rather than by a level. The controller side owns one enable register and inverts it to ask for an access. The memory side owns a second enable register. An access is pending whenever the two enables differ. The memory performs exactly one access, then copies the controller's enable into its own, which clears the request. Each enable therefore has one driver. The memory is idle again at the start and end of every controller cycle.

The top level pairs the memory with a small rising-edge requester. The requester takes one command per cycle, either a load or a store, and returns load data with a valid flag.

Top module: `scratch_stack_mem`

## Requirements
- R1: While reset is applied and after it is released, `rsp_valid` is 0 and `rsp_rdata` is all zeros until the first load returns.
- R2: A load accepted at rising edge N (`req_valid`=1, `req_write`=0) drives `rsp_valid`=1 and `rsp_rdata` = the word stored at `req_addr` from rising edge N+1 until rising edge N+2.
- R3: A store accepted at rising edge N (`req_valid`=1, `req_write`=1) replaces the word at `req_addr` with `req_wdata` before rising edge N+1. It produces no response: `rsp_valid` stays 0 and `rsp_rdata` holds its value.
- R4: A load of an address, accepted on the rising edge right after a store to that same address, returns the newly stored word.
- R5: A command may be accepted on every rising edge. Back-to-back loads each return their own word exactly one cycle after acceptance.
- R6: Cycles with `req_valid`=0 change no stored word, keep `rsp_valid` at 0 one cycle later, and leave `rsp_rdata` unchanged.
- R7: At every rising edge the memory-side enable equals the controller-side enable, so no access is pending when the controller samples.
- R8: Addresses 0 and SIZE-1 are separate words; words are 32 bits wide and every bit is stored.
- R9: A load does not alter memory, whatever value is on `req_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the controller uses the rising edge, the memory the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Command present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | $clog2(SIZE) | Word address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load data valid this cycle |
| rsp_rdata | output | 32 | Load data; holds its last value otherwise |

## Verification
The assertions assume the inputs are stable around each rising edge and that addresses stay below SIZE. The bench drives every command one nanosecond after a rising edge and draws addresses from 0 to SIZE-1 only. The data checks assume that a load targets an address already written since reset. The bench first fills the whole array, and its reference model skips any comparison for an address it has no entry for.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/scratch_rst_sync.sv
module scratch_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/scratch_ram.sv
module scratch_ram
  import scratch_pkg::*;
#(
  parameter int SIZE = 64,
  parameter int AW   = $clog2(SIZE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          u_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  word_t         d_in,
  output word_t         d_out
);
  word_t mem [SIZE];
  logic  en_q, en_d;
  word_t dout_q, dout_d;
  logic  pending;

  assign pending = (u_en != en_q);

  // Next state: one access, then copy the user enable to disarm.
  always_comb begin
    en_d   = en_q;
    dout_d = dout_q;
    if (pending) begin
      en_d = u_en;
      if (!wr_en) dout_d = mem[addr];
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      en_q   <= en_d;
      dout_q <= dout_d;
    end
  end

  always_ff @(negedge clk) begin
    if (pending && wr_en) mem[addr] <= d_in;
  end

  assign d_out = dout_q;

  // R7: the RAM has disarmed itself before every controller edge
  p_disarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_q == u_en);

  // R3: a store issued last edge left d_out untouched
  p_store_keeps_dout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (u_en != $past(u_en) && wr_en) |-> $stable(d_out));

  // R2: a load issued last edge presents the addressed word
  p_load_returns_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (u_en != $past(u_en) && !wr_en) |-> d_out == mem[addr]);
endmodule

// File: rtl/scratch_requester.sv
module scratch_requester
  import scratch_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  word_t         req_wdata,
  input  word_t         d_out,
  output logic          u_en,
  output logic          wr_en,
  output logic [AW-1:0] addr,
  output word_t         d_in,
  output logic          rsp_valid,
  output word_t         rsp_rdata
);
  logic          uen_q, uen_d, wr_q, wr_d, rdp_q, rdp_d, rspv_q, rspv_d;
  logic [AW-1:0] addr_q, addr_d;
  word_t         din_q, din_d, rdat_q, rdat_d;

  always_comb begin
    uen_d  = uen_q;
    wr_d   = wr_q;
    addr_d = addr_q;
    din_d  = din_q;
    rdp_d  = req_valid && !req_write;
    rspv_d = rdp_q;
    rdat_d = rdat_q;
    if (req_valid) begin
      uen_d  = ~uen_q;
      wr_d   = req_write;
      addr_d = req_addr;
      din_d  = req_wdata;
    end
    if (rdp_q) rdat_d = d_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uen_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      din_q  <= '0;
      rdp_q  <= 1'b0;
      rspv_q <= 1'b0;
      rdat_q <= '0;
    end else begin
      uen_q  <= uen_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      din_q  <= din_d;
      rdp_q  <= rdp_d;
      rspv_q <= rspv_d;
      rdat_q <= rdat_d;
    end
  end

  assign u_en      = uen_q;
  assign wr_en     = wr_q;
  assign addr      = addr_q;
  assign d_in      = din_q;
  assign rsp_valid = rspv_q;
  assign rsp_rdata = rdat_q;

  // R2: load accepted -> response two edges later
  p_load_responds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> ##1 rsp_valid);

  // R6: no load accepted -> no response two edges later
  p_no_spurious_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> ##1 !rsp_valid);

  // R6: response data holds while no response is flagged
  p_rdata_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_rdata));
endmodule

// File: rtl/scratch_stack_mem.sv
module scratch_stack_mem
  import scratch_pkg::*;
#(
  parameter int SIZE = 64,
  localparam int AW  = $clog2(SIZE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata
);
  logic          rst_n_s;
  logic          u_en, wr_en;
  logic [AW-1:0] addr;
  word_t         d_in, d_out;

  scratch_rst_sync rst_i (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  scratch_requester #(.AW(AW)) req_i (
    .clk(clk), .rst_n(rst_n_s),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .d_out(d_out), .u_en(u_en), .wr_en(wr_en), .addr(addr), .d_in(d_in),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  scratch_ram #(.SIZE(SIZE), .AW(AW)) ram_i (
    .clk(clk), .rst_n(rst_n_s),
    .u_en(u_en), .wr_en(wr_en), .addr(addr), .d_in(d_in), .d_out(d_out)
  );
endmodule

// File: tb/scratch_stack_mem_tb_top.sv
module scratch_stack_mem_tb_top;
  localparam int SIZE = 64;
  localparam int AW   = $clog2(SIZE);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;

  int checks = 0, errors = 0;
  logic [31:0] model [int];
  logic        pend_v = 1'b0, pend_k = 1'b0;
  logic [31:0] pend_d = '0, last_d = '0;

  always #5 clk = ~clk;

  scratch_stack_mem #(.SIZE(SIZE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One controller cycle: drive a command, pass the edge, check the
  // response owed by the command of the previous call.
  task automatic cyc(input string tag, input logic v, input logic w,
                     input logic [AW-1:0] a, input logic [31:0] d);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    chk({tag, " rsp_valid"}, {31'b0, rsp_valid}, {31'b0, pend_v});
    if (pend_v) begin
      if (pend_k) chk({tag, " rsp_rdata"}, rsp_rdata, pend_d);
      last_d = rsp_rdata;
    end else begin
      chk({tag, " rsp_rdata hold"}, rsp_rdata, last_d);
    end
    pend_v = v && !w;
    pend_k = model.exists(int'(a));
    pend_d = pend_k ? model[int'(a)] : '0;
    if (v && w) model[int'(a)] = d;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    chk("R1 rsp_rdata in reset", rsp_rdata, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    chk("R1 rsp_rdata after reset", rsp_rdata, 32'd0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < SIZE; i++)
      cyc("R3 fill", 1'b1, 1'b1, AW'(i), 32'hA5000000 ^ (i * 32'h01010101));
  endtask

  task automatic t_read_all;
    for (int i = 0; i < SIZE; i++)
      cyc("R2/R5/R7 back-to-back load", 1'b1, 1'b0, AW'(i), 32'h0);
    cyc("R2 drain", 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_raw;
    for (int i = 0; i < 8; i++) begin
      cyc("R4 store", 1'b1, 1'b1, AW'(3 * i + 1), 32'hC0DE0000 + i);
      cyc("R4 load after store", 1'b1, 1'b0, AW'(3 * i + 1), 32'h0);
    end
    cyc("R4 drain", 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 6; i++)
      cyc("R6 idle", 1'b0, 1'b1, AW'(i), 32'hDEADBEEF);
    for (int i = 0; i < 6; i++)
      cyc("R6 unchanged after idle", 1'b1, 1'b0, AW'(i), 32'h0);
    cyc("R6 drain", 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_boundary;
    cyc("R8 store low", 1'b1, 1'b1, '0, 32'hFFFFFFFF);
    cyc("R8 store high", 1'b1, 1'b1, AW'(SIZE - 1), 32'h00000000);
    cyc("R8 load low", 1'b1, 1'b0, '0, 32'h0);
    cyc("R8 load high", 1'b1, 1'b0, AW'(SIZE - 1), 32'h0);
    cyc("R8 store alt", 1'b1, 1'b1, '0, 32'h80000001);
    cyc("R8 load alt", 1'b1, 1'b0, '0, 32'h0);
    cyc("R8 drain", 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_read_wdata;
    cyc("R9 load with wdata", 1'b1, 1'b0, AW'(9), 32'h12345678);
    cyc("R9 load with wdata", 1'b1, 1'b0, AW'(9), 32'h87654321);
    cyc("R9 reload", 1'b1, 1'b0, AW'(9), 32'h0);
    cyc("R9 drain", 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic          v = ($urandom % 4) != 0;
      logic          w = $urandom % 2;
      logic [AW-1:0] a = AW'($urandom % SIZE);
      cyc("R2/R3 random mix", v, w, a, $urandom);
    end
    cyc("R2 drain", 1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    void'($urandom(7));
    t_reset();
    t_fill();
    t_read_all();
    t_raw();
    t_idle();
    t_boundary();
    t_read_wdata();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule